// File: doc/BRIEF.md
# Serial Sampling-Converter Output Framer

This block is the digital side of a serial sampling converter, written as synthesizable logic. It can stand in for the real device in loopback checks of a serial host port. Its own fast clock samples two host-driven lines, a conversion request and a serial clock. A rising edge on the request line, seen while the block is idle, opens a frame. At that moment the block captures the parallel sample word on its input. It then counts the rising edges of the serial clock and drives the serial data line from the captured word, most significant bit first. The first data bit appears on the third counted edge.

A frame lasts sixteen serial clock edges. Until the sixteenth edge, any further conversion request is rejected, and each rejected request is reported by a one-cycle pulse. The block also brings out a busy flag and the number of serial clock edges seen in the current frame. The sample word is 12 or 14 bits wide, set by a parameter. Both widths finish shifting inside the sixteen-edge window.

Top module: `adc_frame_tx`

## Requirements
- R1: After reset the data line, busy flag and ignored flag are 0 and the edge count is 0.
- R2: A rising edge of the request line while busy is 0 sets busy to 1, clears the edge count to 0 and drives the data line to 0.
- R3: The sample word is captured when the request is accepted. Changes on the sample input during the frame do not alter the bits that are shifted out.
- R4: While busy is 1, each serial clock rising edge raises the edge count by one. While busy is 0, serial clock edges leave the edge count and busy unchanged.
- R5: The data line is 0 after serial clock edges 1 and 2 of a frame. The most significant bit of the captured word is driven on edge 3.
- R6: On edge k, for 3 ≤ k ≤ W+2, the data line carries bit W+2−k of the captured word, where W is the sample width. This gives one bit per edge, most significant first.
- R7: On edges after W+2 within a frame, the data line is 0. For W=12 this covers edges 15 and 16.
- R8: Busy falls on the 16th serial clock edge of a frame. The edge count then holds 16 until the next accepted request.
- R9: A request rising edge while busy is 1 is rejected. It raises the ignored flag for exactly one clock cycle, and the frame continues with no change to busy, edge count or data sequence.
- R10: Both inputs pass through a two-stage synchronizer. An input change made between clock edges takes effect at the outputs after the third following rising edge of the internal clock.
- R11: A request accepted after a completed frame starts a fresh frame. The edge count returns to 0 and the data line returns to 0, even if the last bit of the previous frame was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| convIn | input | 1 | Conversion request line, rising edge starts a frame |
| sckIn | input | 1 | Serial clock from the host |
| sampleIn | input | DATA_W | Parallel sample word captured at frame start |
| sdoOut | output | 1 | Serial data line |
| busyOut | output | 1 | High from accepted request to 16th serial clock edge |
| convIgnored | output | 1 | One-cycle pulse for each rejected request |
| sckCount | output | $clog2(FRAME_LEN+1) | Serial clock edges counted in the current frame |

## Verification
The bench builds two copies side by side, one with a 12-bit and one with a 14-bit sample width, and drives both with the same stimulus. The 12-bit copy exposes the two trailing zero edges at the end of the window. The 14-bit copy drives its least significant bit on the 16th edge, which is the very edge on which busy falls. It therefore shows whether a new frame clears a data line that was left at 1. Rejected requests are placed mid-frame, and serial clock edges are also applied while the block is idle.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  // Strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic load;      // capture sample, clear data line
    logic shiftOut;  // drive next bit, advance shift register
    logic zeroOut;   // drive 0 on the data line
  } frameStrobes_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);
  logic [STAGES-1:0] syncChain;
  logic              prevLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[STAGES-2:0], asyncIn};
      prevLevel <= syncChain[STAGES-1];
    end
  end

  assign riseOut = syncChain[STAGES-1] & ~prevLevel;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |=> !riseOut); // R10
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int FRAME_LEN = 16,
  parameter int LEAD      = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           convRise,
  input  logic                           sckRise,
  output logic                           busy,
  output logic                           ignored,
  output logic [$clog2(FRAME_LEN+1)-1:0] edgeCount,
  output frameStrobes_t                  strobes
);
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);
  localparam int FIRST_EDGE = LEAD + 1;
  localparam int LAST_EDGE  = LEAD + DATA_W;

  logic [CNT_W-1:0] nextCount;
  logic             accept;
  logic             countEdge;
  logic             inWindow;

  assign accept    = convRise && !busy;
  assign countEdge = sckRise && busy && !accept;
  assign nextCount = edgeCount + CNT_W'(1);
  assign inWindow  = (int'(nextCount) >= FIRST_EDGE) && (int'(nextCount) <= LAST_EDGE);

  always_comb begin
    strobes          = '0;
    strobes.load     = accept;
    strobes.shiftOut = countEdge && inWindow;
    strobes.zeroOut  = countEdge && !inWindow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      ignored   <= 1'b0;
      edgeCount <= '0;
    end else begin
      ignored <= convRise && busy;
      if (accept) begin
        busy      <= 1'b1;
        edgeCount <= '0;
      end else if (countEdge) begin
        edgeCount <= nextCount;
        if (int'(nextCount) == FRAME_LEN) busy <= 1'b0;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(edgeCount) <= FRAME_LEN); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !convRise) |=> $stable(edgeCount)); // R4
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sckRise && int'(edgeCount) == FRAME_LEN-1) |=> !busy); // R8
  AST_IGNORED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ignored |-> $past(busy)); // R9
  AST_IGNORED_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && convRise && !sckRise) |=> (busy && $stable(edgeCount))); // R9
endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  frameStrobes_t     strobes,
  output logic              sdo
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
    end else if (strobes.load) begin
      shiftReg <= sampleIn;
      sdo      <= 1'b0;
    end else if (strobes.shiftOut) begin
      sdo      <= shiftReg[DATA_W-1];
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (strobes.zeroOut) begin
      sdo      <= 1'b0;
    end
  end

  AST_LOAD_CLEARS_SDO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !sdo); // R11
  AST_ZERO_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroOut |=> !sdo); // R7
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(sdo)); // R6
endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
  import adc_frame_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int FRAME_LEN   = 16,
  parameter int LEAD        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           convIn,
  input  logic                           sckIn,
  input  logic [DATA_W-1:0]              sampleIn,
  output logic                           sdoOut,
  output logic                           busyOut,
  output logic                           convIgnored,
  output logic [$clog2(FRAME_LEN+1)-1:0] sckCount
);
  logic          convRise;
  logic          sckRise;
  frameStrobes_t strobes;

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_convSync (
    .clk(clk), .rstN(rstN), .asyncIn(convIn), .riseOut(convRise));

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sckSync (
    .clk(clk), .rstN(rstN), .asyncIn(sckIn), .riseOut(sckRise));

  adc_frame_ctrl #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .LEAD(LEAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .convRise(convRise), .sckRise(sckRise),
    .busy(busyOut), .ignored(convIgnored), .edgeCount(sckCount), .strobes(strobes));

  adc_frame_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobes(strobes), .sdo(sdoOut));
endmodule

// File: tb/adc_frame_tx_tb.sv
module adc_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convIn = 1'b0;
  logic        sckIn = 1'b0;
  logic [13:0] sample = '0;
  logic        sdoA, busyA, ignA, sdoB, busyB, ignB;
  logic [4:0]  cntA, cntB;
  int          nChecks = 0;
  int          nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // A: 14-bit, B: 12-bit
  adc_frame_tx #(.DATA_W(14)) u_dut (
    .clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn), .sampleIn(sample),
    .sdoOut(sdoA), .busyOut(busyA), .convIgnored(ignA), .sckCount(cntA));

  adc_frame_tx #(.DATA_W(12)) u_dut12 (
    .clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn), .sampleIn(sample[11:0]),
    .sdoOut(sdoB), .busyOut(busyB), .convIgnored(ignB), .sckCount(cntB));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expBit(input logic [13:0] s, input int w, input int k);
    if (k >= 3 && k <= w + 2) return int'(s[w + 2 - k]);
    return 0;
  endfunction

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sckPulse();
    sckIn = 1'b1; waitNeg(4);
    sckIn = 1'b0; waitNeg(4);
  endtask

  // Accept a request and check the frame start state (R2, R11)
  task automatic startFrame(input logic [13:0] s);
    sample = s;
    convIn = 1'b1; waitNeg(4);
    chk("R2 busy14", busyA, 1); chk("R2 busy12", busyB, 1);
    chk("R11 count14", cntA, 0); chk("R11 count12", cntB, 0);
    chk("R11 sdo14", sdoA, 0); chk("R11 sdo12", sdoB, 0);
    convIn = 1'b0; waitNeg(4);
  endtask

  task automatic edgeCheck(input logic [13:0] s, input int k);
    chk($sformatf("R4 count14 k=%0d", k), cntA, k);
    chk($sformatf("R4 count12 k=%0d", k), cntB, k);
    chk($sformatf("R6 sdo14 k=%0d", k), sdoA, expBit(s, 14, k));
    chk($sformatf("R7 sdo12 k=%0d", k), sdoB, expBit(s, 12, k));
    chk($sformatf("R8 busy14 k=%0d", k), busyA, (k < FRAME) ? 1 : 0);
    chk($sformatf("R8 busy12 k=%0d", k), busyB, (k < FRAME) ? 1 : 0);
  endtask

  task automatic tReset();
    waitNeg(3);
    chk("R1 sdo14", sdoA, 0); chk("R1 busy14", busyA, 0);
    chk("R1 ign14", ignA, 0); chk("R1 count14", cntA, 0);
    chk("R1 sdo12", sdoB, 0); chk("R1 busy12", busyB, 0);
    rstN = 1'b1; waitNeg(2);
  endtask

  // Full frame; sample input disturbed after capture (R3, R5, R6, R7, R8)
  task automatic tFrame(input logic [13:0] s);
    startFrame(s);
    sample = ~s;
    for (int k = 1; k <= FRAME; k++) begin
      sckPulse();
      edgeCheck(s, k);
    end
  endtask

  // Input latency through synchronizer (R10)
  task automatic tLatency(input logic [13:0] s);
    sample = s;
    convIn = 1'b1;
    @(negedge clk); chk("R10 busy after 1 edge", busyA, 0);
    @(negedge clk); chk("R10 busy after 2 edges", busyA, 0);
    @(negedge clk); chk("R10 busy after 3 edges", busyA, 1);
    waitNeg(2); convIn = 1'b0; waitNeg(4);
    for (int k = 1; k <= FRAME; k++) begin
      sckPulse();
      if (k == 3) chk("R5 msb14 edge3", sdoA, int'(s[13]));
      if (k == 2) chk("R5 zero edge2", sdoA, 0);
    end
  endtask

  // Rejected request mid-frame (R9)
  task automatic tIgnore(input logic [13:0] s);
    int pulses = 0;
    startFrame(s);
    for (int k = 1; k <= 5; k++) sckPulse();
    convIn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ignA) pulses++;
    end
    chk("R9 ignored pulse count", pulses, 1);
    chk("R9 busy kept", busyA, 1);
    chk("R9 count kept", cntA, 5);
    convIn = 1'b0; waitNeg(4);
    chk("R9 ign low", ignB, 0);
    for (int k = 6; k <= FRAME; k++) begin
      sckPulse();
      edgeCheck(s, k);
    end
  endtask

  // Serial clock while idle (R4)
  task automatic tIdleSck();
    for (int i = 0; i < 3; i++) sckPulse();
    chk("R4 idle count14", cntA, FRAME); chk("R4 idle count12", cntB, FRAME);
    chk("R4 idle busy14", busyA, 0);
  endtask

  initial begin
    tReset();
    tFrame(14'h2A5B);
    tIdleSck();
    tFrame(14'h3FFF);
    tFrame(14'h0001);
    tLatency(14'h2000);
    tIgnore(14'h1C3D);
    tFrame(14'h1555);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule